// File: doc/BRIEF.md
# Programmable Pin Toggle Stimulus Generator

This block produces a square wave on one output pin for use as test stimulus on an input of a neighbouring block. Software programs a high time and a low time, both counted in bus-clock enable pulses, and a repeat count, all through a small write port. Once armed, the block runs a phase down-counter. Each time the counter expires the pin is inverted and the counter is reloaded with the duration that belongs to the level just entered.

Each expiry spends one unit of the repeat budget. The sequence ends when the budget is exhausted, when a clear command arrives, or when the sequence is reset. Loading the all-ones repeat value makes the wave run without end. An active flag shows whether a sequence is running, and the pin level can be read at all times. Converting times or frequencies to pulse counts is left to the writer.

Top module: `pin_toggle_gen`

## Requirements
- R1: While a sequence is active, the pin inverts on the enable pulse that ends the current phase, so a phase of length L lasts exactly L enable pulses.
- R2: After a toggle the phase length is the high time when the new level is 1, and the low time when the new level is 0.
- R3: With a programmed repeat value N, an armed sequence makes exactly N+1 transitions and then drops `active_o` on the edge of the last one.
- R4: A written high or low time of zero is stored and used as one pulse.
- R5: Arming discards any pending phase and copies the programmed repeat value. The first phase then uses the duration that matches the current pin level. Arming leaves the pin unchanged.
- R6: `clear_i` stops the sequence and zeroes the working repeat count while holding the pin level. It takes priority over `arm_i` in the same cycle. The pin changes only on an expiry or a sequence reset.
- R7: `seq_rst_i` stops any sequence and drives the pin to 0. It takes priority over every other command.
- R8: Asserting `rst_ni` low at once forces the pin to 0 and `active_o` to 0. It also sets the high and low times to 1 and the repeat value to 0.
- R9: A repeat value of all ones never counts down, so the toggling continues until it is cleared or reset.
- R10: The phase counter advances only in cycles where `tick_i` is high.
- R11: A write with `wr_en_i` high stores `wr_data_i` into the register chosen by `wr_sel_i`: 2'd0 selects the high time, 2'd1 the low time and 2'd2 the repeat value. A written duration takes effect at the next phase load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bus-clock enable; one phase count per pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 high time, 1 low time, 2 repeat |
| wr_data_i | input | DATA_W | Write data |
| arm_i | input | 1 | Start or restart the sequence |
| clear_i | input | 1 | Stop the sequence and hold the pin |
| seq_rst_i | input | 1 | Stop the sequence and drive the pin low |
| pin_o | output | 1 | Generated pin level |
| active_o | output | 1 | Sequence running |

## Verification
The assertions assume that the command inputs are single-cycle pulses with defined values. They also assume the write data fits the register widths, so a programmed duration never reaches the counter as anything other than a value of at least one. The stimulus drives every input at the falling edge and holds it for one full cycle. It writes the registers only while no sequence is running, or, in the restart case, only into a register the running phase does not use. The enable pulses follow a fixed period, so the expected edge of every transition can be computed in advance.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    SEL_ON   = 2'd0,
    SEL_OFF  = 2'd1,
    SEL_REP  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  localparam int unsigned NUM_DUR = 2;  // index 0: high time, 1: low time
endpackage

// File: rtl/ptg_cfg_regs.sv
module ptg_cfg_regs #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned REP_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  on_o,
  output logic [CNT_W-1:0]  off_o,
  output logic [REP_W-1:0]  rep_o
);
  import ptg_pkg::*;

  localparam logic [CNT_W-1:0] DUR_MIN = CNT_W'(1);

  wr_sel_e           sel;
  logic [CNT_W-1:0]  dur_q [NUM_DUR];
  logic [CNT_W-1:0]  dur_wr;
  logic [REP_W-1:0]  rep_q;

  assign sel    = wr_sel_e'(wr_sel_i);
  // sub-cycle durations are forced to one pulse
  assign dur_wr = (wr_data_i[CNT_W-1:0] == '0) ? DUR_MIN : wr_data_i[CNT_W-1:0];

  for (genvar g = 0; g < NUM_DUR; g++) begin : g_dur
    localparam wr_sel_e MY_SEL = (g == 0) ? SEL_ON : SEL_OFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       dur_q[g] <= DUR_MIN;
      else if (wr_en_i && sel == MY_SEL) dur_q[g] <= dur_wr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rep_q <= '0;
    else if (wr_en_i && sel == SEL_REP) rep_q <= wr_data_i[REP_W-1:0];
  end

  assign on_o  = dur_q[0];
  assign off_o = dur_q[1];
  assign rep_o = rep_q;

  AST_DUR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_o != '0) && (off_o != '0)); // R4
endmodule

// File: rtl/ptg_phase_timer.sv
module ptg_phase_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (run_i && tick_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = run_i && tick_i && (cnt_q == CNT_LAST);

  AST_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q != '0)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !load_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/ptg_seq_ctrl.sv
module ptg_seq_ctrl #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned REP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             clear_i,
  input  logic             seq_rst_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic [REP_W-1:0] rep_cfg_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             pin_o,
  output logic             active_o
);
  localparam logic [REP_W-1:0] REP_INF = '1;

  logic             pin_q, active_q;
  logic [REP_W-1:0] rep_q;
  logic             quiet, last, next_lvl;

  assign quiet    = !seq_rst_i && !clear_i;
  assign last     = (rep_q == '0);
  // arm reloads for the current level, expiry for the level about to be entered
  assign next_lvl = arm_i ? pin_q : ~pin_q;
  assign load_val_o = next_lvl ? on_i : off_i;
  assign load_o   = quiet && (arm_i || (expire_i && !last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q    <= 1'b0;
      active_q <= 1'b0;
      rep_q    <= '0;
    end else if (seq_rst_i) begin
      pin_q    <= 1'b0;
      active_q <= 1'b0;
      rep_q    <= '0;
    end else if (clear_i) begin
      active_q <= 1'b0;
      rep_q    <= '0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      rep_q    <= rep_cfg_i;
    end else if (expire_i) begin
      pin_q <= ~pin_q;
      if (last)                 active_q <= 1'b0;
      else if (rep_q != REP_INF) rep_q   <= rep_q - REP_W'(1);
    end
  end

  assign pin_o    = pin_q;
  assign active_o = active_q;

  AST_TOGGLE_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && quiet && !arm_i) |=> (pin_o != $past(pin_o))); // R1
  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expire_i && !seq_rst_i) |=> $stable(pin_o)); // R6
  AST_CLEAR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !seq_rst_i) |=> (!active_o && $stable(pin_o))); // R6
  AST_LAST_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && quiet && !arm_i && rep_q == '0) |=> !active_o); // R3
  AST_CONT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && quiet && !arm_i && rep_q == REP_INF) |=> (active_o && rep_q == REP_INF)); // R9
  AST_SEQ_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rst_i |=> (!pin_o && !active_o)); // R7
  AST_ARM_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && quiet) |=> (active_o && $stable(pin_o))); // R5
endmodule

// File: rtl/pin_toggle_gen.sv
module pin_toggle_gen #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned REP_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              arm_i,
  input  logic              clear_i,
  input  logic              seq_rst_i,
  output logic              pin_o,
  output logic              active_o
);
  logic [CNT_W-1:0] on_val, off_val, load_val;
  logic [REP_W-1:0] rep_cfg;
  logic             load, expire;

  initial begin
    if (CNT_W > DATA_W || REP_W > DATA_W || CNT_W < 2)
      $error("pin_toggle_gen: register widths must fit the write data");
  end

  ptg_cfg_regs #(.CNT_W(CNT_W), .REP_W(REP_W), .DATA_W(DATA_W)) cfg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .on_o      (on_val),
    .off_o     (off_val),
    .rep_o     (rep_cfg)
  );

  ptg_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (active_o),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

  ptg_seq_ctrl #(.CNT_W(CNT_W), .REP_W(REP_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .clear_i    (clear_i),
    .seq_rst_i  (seq_rst_i),
    .expire_i   (expire),
    .on_i       (on_val),
    .off_i      (off_val),
    .rep_cfg_i  (rep_cfg),
    .load_o     (load),
    .load_val_o (load_val),
    .pin_o      (pin_o),
    .active_o   (active_o)
  );
endmodule

// File: tb/pin_toggle_gen_tb_top.sv
module pin_toggle_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic        arm_i = 1'b0;
  logic        clear_i = 1'b0;
  logic        seq_rst_i = 1'b0;
  logic        pin_o, active_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pin_toggle_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .arm_i(arm_i),
    .clear_i(clear_i), .seq_rst_i(seq_rst_i), .pin_o(pin_o), .active_o(active_o)
  );

  // vectors: high time, low time, repeat, enable period
  localparam int NV = 6;
  localparam int VEC_ON  [NV] = '{3, 1, 0, 2, 4, 7};
  localparam int VEC_OFF [NV] = '{5, 1, 4, 0, 2, 1};
  localparam int VEC_REP [NV] = '{3, 0, 2, 4, 2, 1};
  localparam int VEC_GAP [NV] = '{1, 1, 1, 1, 3, 1};

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk);
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic run_vec(input int on, input int off, input int rep, input int gap);
    logic start, lvl, prev;
    int   exp_t, togs, limit;
    wr(2'd0, 32'(on));
    wr(2'd1, 32'(off));
    wr(2'd2, 32'(rep));
    start = pin_o;
    @(negedge clk);
    arm_i = 1'b1; tick_i = 1'b0;
    @(negedge clk);
    arm_i = 1'b0;
    tick_i = ((1 % gap) == 0);
    chk("R5 active after arm", active_o, 1);
    chk("R5 pin kept by arm", pin_o, start);
    lvl = start; prev = start; togs = 0;
    exp_t = gap * (lvl ? eff(on) : eff(off));
    limit = gap * (rep + 1) * (eff(on) + eff(off)) + 4 * gap + 4;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (pin_o != prev) begin
        togs++;
        chk("R1/R2/R4/R10/R11 toggle cycle", n, exp_t);
        lvl = ~lvl;
        exp_t += gap * (lvl ? eff(on) : eff(off));
        chk("R3 active at toggle", active_o, (togs == rep + 1) ? 0 : 1);
        prev = pin_o;
      end
      tick_i = (((n + 1) % gap) == 0);
    end
    tick_i = 1'b0;
    chk("R3 transition count", togs, rep + 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic p;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 reset pin", pin_o, 0);
    chk("R8 reset active", active_o, 0);

    for (int v = 0; v < NV; v++) run_vec(VEC_ON[v], VEC_OFF[v], VEC_REP[v], VEC_GAP[v]);

    // R6: clear mid-run, together with arm
    wr(2'd0, 10); wr(2'd1, 10); wr(2'd2, 5);
    tick_i = 1'b1;
    pulse_arm();
    repeat (3) @(negedge clk);
    p = pin_o;
    clear_i = 1'b1; arm_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0; arm_i = 1'b0;
    chk("R6 clear stops", active_o, 0);
    cnt = 0;
    for (int n = 0; n < 25; n++) begin
      @(negedge clk);
      if (pin_o != p) cnt++;
    end
    chk("R6 pin held after clear", cnt, 0);

    // R7: sequence reset forces pin low
    @(negedge clk); seq_rst_i = 1'b1;
    @(negedge clk); seq_rst_i = 1'b0;
    chk("R7 pin low", pin_o, 0);
    chk("R7 inactive", active_o, 0);

    // R5: re-arm restarts the pending phase
    wr(2'd0, 6); wr(2'd1, 6); wr(2'd2, 3);
    pulse_arm();
    repeat (3) @(negedge clk);
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    cnt = 0;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (pin_o && cnt == 0) cnt = n;
    end
    chk("R5 first toggle after re-arm", cnt, 6);
    clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;

    // R9: continuous mode
    wr(2'd0, 2); wr(2'd1, 2); wr(2'd2, 32'hFFFF_FFFF);
    pulse_arm();
    p = pin_o; cnt = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (pin_o != p) begin cnt++; p = pin_o; end
    end
    chk("R9 continuous toggles", cnt, 20);
    chk("R9 still active", active_o, 1);
    for (int n = 0; n < 4 && !pin_o; n++) @(negedge clk);
    chk("R9 pin high before reset", pin_o, 1);
    seq_rst_i = 1'b1;
    @(negedge clk); seq_rst_i = 1'b0;
    chk("R7 pin low from high", pin_o, 0);
    chk("R7 continuous stopped", active_o, 0);

    // R8: asynchronous reset mid-run, then defaults
    wr(2'd0, 5); wr(2'd1, 5); wr(2'd2, 10);
    pulse_arm();
    repeat (7) @(negedge clk);
    #2 rst_ni = 1'b0;
    #1;
    chk("R8 async pin", pin_o, 0);
    chk("R8 async active", active_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    pulse_arm();
    @(negedge clk);
    chk("R8 default durations one pulse", pin_o, 1);
    chk("R8 default repeat zero", active_o, 0);
    tick_i = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule